// File: doc/BRIEF.md
# Boot-Time Flash Loader Master

This block runs once after power-on. It holds the processor core in reset, reads a list of load records from an external flash and writes the payload of each record into on-chip memories over the system bus. Nothing the core needs to run is fixed on chip: microcode, boot code, clock settings and bus wait states all arrive through this path. The loader requests the bus at top priority from the moment reset is applied and needs no permission from the core, which is held in reset the whole time.

A record is a destination byte address word, then a count word whose low 16 bits give the number of data words, then the data words. A record whose count is zero closes the list. When the list is closed, the loader drops its bus request, raises its done flag and releases the core. From then on it is inert until the next power-on reset. If the very first word read from flash is all ones, the flash is taken to be blank: nothing is written, the error flag is raised and the core stays held in reset.

Top module: `boot_loader`

## Requirements
- R1: While reset is applied, core_rst_n is 0, load_done is 0, load_err is 0, bus_req is 1, bus_wr is 0, and a flash read is requested at flash word address 0.
- R2: Flash words are read at word addresses 0, 1, 2 and upward. Each record consists of a destination byte address word, then a count word whose bits [15:0] give the word count (bits [31:16] are ignored), then that many data words. Data word i of a record is written to the destination address plus 4*i.
- R3: Records are handled one after another. A record whose count field is zero ends the list: its address word is consumed, nothing is written for it, and flash words after it are never written to the bus.
- R4: A write keeps bus_wr, bus_addr and bus_wdata unchanged until a cycle in which bus_gnt and bus_ready are both 1. A cycle with only one of them high completes nothing, and each data word is written exactly once.
- R5: bus_req is 1 from reset until loading ends and 0 from then on.
- R6: core_rst_n stays 0 until the terminating record has been processed without error, and then stays 1.
- R7: load_done rises when loading ends and never falls without a reset. After that, no flash read or bus write is issued, whatever fl_ack, bus_gnt and bus_ready do.
- R8: If the first address word read after reset is 0xFFFFFFFF, no write is issued, load_done and load_err both become 1, and core_rst_n stays 0. An all-ones address word in any later record is treated as an ordinary destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| fl_rd | output | 1 | Flash read request, held until acknowledged |
| fl_addr | output | 16 | Flash word address of the pending read |
| fl_ack | input | 1 | One-cycle flash acknowledge; fl_rdata is valid with it |
| fl_rdata | input | 32 | Flash read data |
| bus_req | output | 1 | Top-priority bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_wr | output | 1 | Write command valid |
| bus_addr | output | 32 | Write byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Target ready; the write completes when both grant and ready are high |
| core_rst_n | output | 1 | Active-low reset to the processor core |
| load_done | output | 1 | Loading has ended (sticky) |
| load_err | output | 1 | Flash found blank, nothing was loaded |

## Verification
Grant and ready are separate inputs that the bus drives independently, so the two conditions that finish a write can arrive in different cycles or in the same one. The bench drives them in opposite phase for several cycles while a write is pending and expects no completed write and an unchanged address and data. It then drives them together and expects each word to land exactly once at its address. A second overlap is a spurious flash acknowledge that arrives once loading has ended: the bench forces acknowledges and grants after done and expects no read request, no write and no change to the done or reset outputs.

// File: rtl/bld_pkg.sv
package bld_pkg;
  typedef enum logic [2:0] {
    ST_HDR_ADDR,
    ST_HDR_CNT,
    ST_DATA_RD,
    ST_WRITE,
    ST_DONE
  } bld_state_e;
endpackage

// File: rtl/bld_rst_sync.sv
module bld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/bld_ctrl.sv
module bld_ctrl
  import bld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fl_ack,
  input  logic rdata_ones,
  input  logic cnt_zero,
  input  logic last_word,
  input  logic bus_gnt,
  input  logic bus_ready,
  output logic fl_rd,
  output logic fl_adv,
  output logic ld_dst,
  output logic ld_cnt,
  output logic ld_data,
  output logic wr_done,
  output logic bus_wr,
  output logic done,
  output logic err
);
  bld_state_e state_q, state_d;
  logic       first_q, first_d;
  logic       err_q, err_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    first_d = first_q;
    err_d   = err_q;
    ld_dst  = 1'b0;
    ld_cnt  = 1'b0;
    ld_data = 1'b0;
    wr_done = 1'b0;
    unique case (state_q)
      ST_HDR_ADDR: if (fl_ack) begin
        first_d = 1'b0;
        if (first_q && rdata_ones) begin
          state_d = ST_DONE;
          err_d   = 1'b1;
        end else begin
          ld_dst  = 1'b1;
          state_d = ST_HDR_CNT;
        end
      end
      ST_HDR_CNT: if (fl_ack) begin
        if (cnt_zero) begin
          state_d = ST_DONE;
        end else begin
          ld_cnt  = 1'b1;
          state_d = ST_DATA_RD;
        end
      end
      ST_DATA_RD: if (fl_ack) begin
        ld_data = 1'b1;
        state_d = ST_WRITE;
      end
      ST_WRITE: if (bus_gnt && bus_ready) begin
        wr_done = 1'b1;
        state_d = last_word ? ST_HDR_ADDR : ST_DATA_RD;
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_DONE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR_ADDR;
      first_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      err_q   <= err_d;
    end
  end

  assign fl_rd  = (state_q == ST_HDR_ADDR) || (state_q == ST_HDR_CNT) ||
                  (state_q == ST_DATA_RD);
  assign fl_adv = fl_rd && fl_ack;
  assign bus_wr = (state_q == ST_WRITE);
  assign done   = (state_q == ST_DONE);
  assign err    = err_q;

  // R7: once done, the loader stays done
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R7: nothing is issued after done
  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!fl_rd && !bus_wr));
  // R4: a pending write without both grant and ready stays pending
  a_r4_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(bus_gnt && bus_ready)) |=> bus_wr);
  // R8: the error flag only rises together with the end of loading
  a_r8_err_ends_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

// File: rtl/bld_dpath.sv
module bld_dpath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int FL_AW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              fl_adv,
  input  logic              ld_dst,
  input  logic              ld_cnt,
  input  logic              ld_data,
  input  logic              wr_done,
  output logic [FL_AW-1:0]  fl_addr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              rdata_ones,
  output logic              cnt_zero,
  output logic              last_word
);
  localparam int STRIDE = DATA_W / 8;

  logic [FL_AW-1:0]  fl_ptr_q, fl_ptr_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [DATA_W-1:0] data_q;
  logic              dst_en, rem_en;

  // next-state logic
  always_comb begin
    fl_ptr_d = fl_ptr_q + FL_AW'(1);
    dst_en   = ld_dst || wr_done;
    dst_d    = ld_dst ? fl_rdata[ADDR_W-1:0] : dst_q + ADDR_W'(STRIDE);
    rem_en   = ld_cnt || wr_done;
    rem_d    = ld_cnt ? fl_rdata[CNT_W-1:0] : rem_q - CNT_W'(1);
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ptr_q <= '0;
      dst_q    <= '0;
      rem_q    <= '0;
      data_q   <= '0;
    end else begin
      if (fl_adv)  fl_ptr_q <= fl_ptr_d;
      if (dst_en)  dst_q    <= dst_d;
      if (rem_en)  rem_q    <= rem_d;
      if (ld_data) data_q   <= fl_rdata;
    end
  end

  assign fl_addr    = fl_ptr_q;
  assign bus_addr   = dst_q;
  assign bus_wdata  = data_q;
  assign rdata_ones = &fl_rdata;
  assign cnt_zero   = (fl_rdata[CNT_W-1:0] == '0);
  assign last_word  = (rem_q == CNT_W'(1));

  // R2: each completed write moves the destination by one word
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (bus_addr == $past(bus_addr) + ADDR_W'(STRIDE)));
  // R2: each accepted flash word moves the flash pointer by one
  a_r2_flash_step: assert property (@(posedge clk) disable iff (!rst_n)
    fl_adv |=> (fl_addr == $past(fl_addr) + FL_AW'(1)));
  // R4: write data does not change while a write is pending
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_data |=> $stable(bus_wdata));
endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int FL_AW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fl_rd,
  output logic [FL_AW-1:0]  fl_addr,
  input  logic              fl_ack,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  output logic              core_rst_n,
  output logic              load_done,
  output logic              load_err
);
  logic srst_n;
  logic fl_adv, ld_dst, ld_cnt, ld_data, wr_done;
  logic rdata_ones, cnt_zero, last_word;
  logic done, err;

  bld_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  bld_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .fl_ack     (fl_ack),
    .rdata_ones (rdata_ones),
    .cnt_zero   (cnt_zero),
    .last_word  (last_word),
    .bus_gnt    (bus_gnt),
    .bus_ready  (bus_ready),
    .fl_rd      (fl_rd),
    .fl_adv     (fl_adv),
    .ld_dst     (ld_dst),
    .ld_cnt     (ld_cnt),
    .ld_data    (ld_data),
    .wr_done    (wr_done),
    .bus_wr     (bus_wr),
    .done       (done),
    .err        (err)
  );

  bld_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .FL_AW  (FL_AW)
  ) i_dpath (
    .clk        (clk),
    .rst_n      (srst_n),
    .fl_rdata   (fl_rdata),
    .fl_adv     (fl_adv),
    .ld_dst     (ld_dst),
    .ld_cnt     (ld_cnt),
    .ld_data    (ld_data),
    .wr_done    (wr_done),
    .fl_addr    (fl_addr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rdata_ones (rdata_ones),
    .cnt_zero   (cnt_zero),
    .last_word  (last_word)
  );

  assign bus_req    = !done;
  assign load_done  = done;
  assign load_err   = err;
  assign core_rst_n = done && !err;

  // R6: the core is never released before loading ends
  a_r6_core_held: assert property (@(posedge clk) disable iff (!srst_n)
    !load_done |-> !core_rst_n);
  // R8: a blank flash keeps the core in reset
  a_r8_blank_holds_core: assert property (@(posedge clk) disable iff (!srst_n)
    load_err |-> !core_rst_n);
  // R5: the bus request only drops when loading ends
  a_r5_req_until_done: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(bus_req) |-> load_done);
endmodule

// File: tb/test_boot_loader.sv
module test_boot_loader;
  logic        clk;
  logic        rst_n;
  logic        fl_rd;
  logic [15:0] fl_addr;
  logic        fl_ack;
  logic [31:0] fl_rdata;
  logic        bus_req;
  logic        bus_gnt;
  logic        bus_wr;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic        core_rst_n;
  logic        load_done;
  logic        load_err;

  int checks;
  int errors;

  logic [31:0] fmem [64];
  int          fp;
  int          fl_lat;
  logic        spurious;
  int          bus_mode;
  int          cyc;

  logic [31:0] exp_addr [32];
  logic [31:0] exp_data [32];
  int          nexp;
  logic [31:0] obs_addr [32];
  logic [31:0] obs_data [32];
  int          nobs;

  boot_loader i_boot_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .fl_rd      (fl_rd),
    .fl_addr    (fl_addr),
    .fl_ack     (fl_ack),
    .fl_rdata   (fl_rdata),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .core_rst_n (core_rst_n),
    .load_done  (load_done),
    .load_err   (load_err)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // flash model: acknowledges a held read after fl_lat idle cycles
  initial begin
    int lat_cnt;
    lat_cnt  = 0;
    fl_ack   = 1'b0;
    fl_rdata = '0;
    forever begin
      @(negedge clk);
      if (spurious) begin
        fl_ack   = 1'b1;
        fl_rdata = 32'hFFFF_FFFF;
      end else if (fl_ack) begin
        fl_ack  = 1'b0;
        lat_cnt = 0;
      end else if (fl_rd) begin
        if (lat_cnt >= fl_lat) begin
          fl_ack   = 1'b1;
          fl_rdata = fmem[fl_addr[5:0]];
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  // bus model: drives grant/ready and logs every completed write
  initial begin
    cyc       = 0;
    bus_gnt   = 1'b0;
    bus_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (bus_mode)
        1:       begin bus_gnt = cyc[0];          bus_ready = !cyc[0];        end
        2:       begin bus_gnt = (cyc % 3 != 0);  bus_ready = (cyc % 2 == 0); end
        default: begin bus_gnt = 1'b1;            bus_ready = 1'b1;           end
      endcase
      if (rst_n && bus_wr && bus_gnt && bus_ready) begin
        if (nobs < 32) begin
          obs_addr[nobs] = bus_addr;
          obs_data[nobs] = bus_wdata;
        end
        nobs++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    fmem[fp] = w;
    fp++;
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
    exp_addr[nexp] = a;
    exp_data[nexp] = d;
    nexp++;
  endtask

  task automatic clear_image();
    for (int i = 0; i < 64; i++) fmem[i] = 32'h0;
    fp   = 0;
    nexp = 0;
  endtask

  task automatic apply_reset(input int mode, input int lat, input bit check_idle);
    rst_n    = 1'b0;
    bus_mode = mode;
    fl_lat   = lat;
    spurious = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    nobs = 0;
    if (check_idle) begin
      chk("R1", "core_rst_n in reset", 64'(core_rst_n), 64'd0);
      chk("R1", "load_done in reset",  64'(load_done),  64'd0);
      chk("R1", "load_err in reset",   64'(load_err),   64'd0);
      chk("R1", "bus_req in reset",    64'(bus_req),    64'd1);
      chk("R1", "bus_wr in reset",     64'(bus_wr),     64'd0);
      chk("R1", "fl_rd in reset",      64'(fl_rd),      64'd1);
      chk("R1", "fl_addr in reset",    64'(fl_addr),    64'd0);
    end
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    bit seen_bad_req;
    bit seen_early_core;
    seen_bad_req    = 1'b0;
    seen_early_core = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #2;
      if (load_done) break;
      if (!bus_req)   seen_bad_req    = 1'b1;
      if (core_rst_n) seen_early_core = 1'b1;
    end
    chk(req,  "load_done reached",         64'(load_done),       64'd1);
    chk("R5", "bus_req high while loading", 64'(seen_bad_req),    64'd0);
    chk("R6", "core held while loading",    64'(seen_early_core), 64'd0);
  endtask

  task automatic compare_writes(input string req);
    chk(req, "number of writes", 64'(nobs), 64'(nexp));
    for (int i = 0; i < nexp && i < nobs; i++) begin
      chk(req, "write address", 64'(obs_addr[i]), 64'(exp_addr[i]));
      chk(req, "write data",    64'(obs_data[i]), 64'(exp_data[i]));
    end
  endtask

  task automatic check_released(input string req);
    chk(req,  "load_err",   64'(load_err),   64'd0);
    chk("R6", "core_rst_n", 64'(core_rst_n), 64'd1);
    chk("R5", "bus_req",    64'(bus_req),    64'd0);
  endtask

  // R1 then R2: single record, full speed
  task automatic t_single();
    clear_image();
    put(32'h0000_1000); put(32'd3);
    put(32'hA000_0001); put(32'hA000_0002); put(32'hA000_0003);
    put(32'h0); put(32'h0);
    expect_wr(32'h0000_1000, 32'hA000_0001);
    expect_wr(32'h0000_1004, 32'hA000_0002);
    expect_wr(32'h0000_1008, 32'hA000_0003);
    apply_reset(0, 0, 1'b1);
    wait_done("R2");
    compare_writes("R2");
    check_released("R2");
  endtask

  // R3: several records, upper count bits ignored, data after terminator unused
  task automatic t_multi();
    clear_image();
    put(32'h0000_2000); put(32'hFFFF_0002);
    put(32'hB000_0001); put(32'hB000_0002);
    put(32'h8000_0010); put(32'h0000_0001);
    put(32'hC000_0001);
    put(32'h1234_5678); put(32'h0001_0000);
    put(32'h0000_3000); put(32'd1); put(32'hDEAD_BEEF);
    expect_wr(32'h0000_2000, 32'hB000_0001);
    expect_wr(32'h0000_2004, 32'hB000_0002);
    expect_wr(32'h8000_0010, 32'hC000_0001);
    apply_reset(2, 2, 1'b0);
    wait_done("R3");
    compare_writes("R3");
    check_released("R3");
  endtask

  // R3: a zero count in the first record ends the list at once
  task automatic t_zero_first();
    clear_image();
    put(32'h0000_5000); put(32'h0);
    put(32'hEEEE_EEEE); put(32'hEEEE_EEEE);
    apply_reset(0, 1, 1'b0);
    wait_done("R3");
    compare_writes("R3");
    check_released("R3");
  endtask

  // R4: grant and ready in opposite phase must not complete a write
  task automatic t_handshake();
    logic [31:0] held_a;
    logic [31:0] held_d;
    bit          moved;
    clear_image();
    put(32'h0000_4000); put(32'd2);
    put(32'h4444_0001); put(32'h4444_0002);
    put(32'h0); put(32'h0);
    expect_wr(32'h0000_4000, 32'h4444_0001);
    expect_wr(32'h0000_4004, 32'h4444_0002);
    apply_reset(1, 0, 1'b0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #2;
      if (bus_wr) break;
    end
    chk("R4", "write pending", 64'(bus_wr), 64'd1);
    held_a = bus_addr;
    held_d = bus_wdata;
    moved  = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #2;
      if (!bus_wr || bus_addr !== held_a || bus_wdata !== held_d) moved = 1'b1;
    end
    chk("R4", "write held without grant and ready together", 64'(moved), 64'd0);
    chk("R4", "no write completed in opposite phase",         64'(nobs),  64'd0);
    bus_mode = 0;
    wait_done("R4");
    compare_writes("R4");
    check_released("R4");
  endtask

  // R8: blank flash
  task automatic t_erased();
    clear_image();
    put(32'hFFFF_FFFF); put(32'd2);
    put(32'h1111_1111); put(32'h2222_2222);
    put(32'h0); put(32'h0);
    apply_reset(0, 0, 1'b0);
    wait_done("R8");
    chk("R8", "no writes on blank flash", 64'(nobs),       64'd0);
    chk("R8", "load_err",                 64'(load_err),   64'd1);
    chk("R8", "core_rst_n held",          64'(core_rst_n), 64'd0);
    chk("R5", "bus_req after blank",      64'(bus_req),    64'd0);
  endtask

  // R8: an all-ones address in a later record is an ordinary address
  task automatic t_ones_later();
    clear_image();
    put(32'h0000_0100); put(32'd1); put(32'h7777_0001);
    put(32'hFFFF_FFFF); put(32'd1); put(32'h7777_0002);
    put(32'h0); put(32'h0);
    expect_wr(32'h0000_0100, 32'h7777_0001);
    expect_wr(32'hFFFF_FFFF, 32'h7777_0002);
    apply_reset(0, 0, 1'b0);
    wait_done("R8");
    compare_writes("R8");
    check_released("R8");
  endtask

  // R7: after done, forced acknowledges and grants change nothing
  task automatic t_sticky();
    bit activity;
    int nobs_before;
    clear_image();
    put(32'h0000_0200); put(32'd1); put(32'h9999_0001);
    put(32'h0); put(32'h0);
    expect_wr(32'h0000_0200, 32'h9999_0001);
    apply_reset(0, 0, 1'b0);
    wait_done("R7");
    compare_writes("R7");
    nobs_before = nobs;
    activity    = 1'b0;
    spurious    = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #2;
      if (fl_rd || bus_wr || bus_req || !load_done || !core_rst_n) activity = 1'b1;
    end
    spurious = 1'b0;
    chk("R7", "outputs quiet after done",  64'(activity), 64'd0);
    chk("R7", "no write after done",       64'(nobs),     64'(nobs_before));
    chk("R7", "load_done still set",       64'(load_done), 64'd1);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    nobs     = 0;
    nexp     = 0;
    fp       = 0;
    fl_lat   = 0;
    spurious = 1'b0;
    bus_mode = 0;
    rst_n    = 1'b0;
    for (int i = 0; i < 64; i++) fmem[i] = 32'h0;
    repeat (2) @(negedge clk);
    t_single();
    t_multi();
    t_zero_first();
    t_handshake();
    t_erased();
    t_ones_later();
    t_sticky();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule